// File: doc/BRIEF.md
# Bridge Memory Window Claim Decoder

This block sits beside the address path of a two-bus bridge and decides, for every memory transaction seen on either of its two buses, whether the bridge should claim it and pass it across or leave it alone. The near side is the primary bus. The far side is the secondary bus.

It compares each address against three windows:
- a prefetchable memory window, given by a base and a limit;
- a memory-mapped I/O window, also given by a base and a limit;
- the legacy display memory range, which is honored only when its enable input is set.

Transactions on the primary side are claimed for downstream forwarding when they fall in any of the three windows. Transactions on the secondary side are claimed for upstream forwarding only when they fall in none of them.

A third output marks addresses in the prefetchable window. The surrounding read logic uses it to decide whether a read may fetch ahead of the request.

All three outputs are registered. The decision for a transaction presented at one clock edge appears after that edge and holds for one cycle. Window bases and limits are given in 1 MB units, as the upper address bits.

Top module: `bridge_window_decode`

## Requirements
- R1: While reset is asserted, and after it is released until a valid transaction is decoded, `claim_dn`, `claim_up` and `pf_hit` are all 0.
- R2: A valid primary-side transaction (`txn_side`=0) whose address is inside the prefetchable window gives `claim_dn`=1.
- R3: A valid secondary-side transaction (`txn_side`=1) whose address is inside the prefetchable window gives `claim_up`=0.
- R4: A valid primary-side transaction gives `claim_dn`=1 if it hits the memory-mapped I/O window or the enabled display range, and `claim_dn`=0 if it misses all three windows. `claim_up` is always 0 for primary-side transactions.
- R5: A valid secondary-side transaction gives `claim_up`=1 only when it misses all three windows; otherwise `claim_up`=0. `claim_dn` is always 0 for secondary-side transactions.
- R6: `pf_hit`=1 exactly when a valid transaction, on either side, is inside the prefetchable window.
- R7: A window with base B and limit L covers addresses B*2^20 through L*2^20 + 0xFFFFF, both ends included. A window with L < B covers nothing.
- R8: The display range covers addresses 0xA0000 through 0xBFFFF and takes part in the decode only when `vga_en`=1.
- R9: Outputs are registered. The result for the inputs sampled at a rising edge is visible after that edge. A cycle with `txn_valid`=0 gives all three outputs 0 after the next edge.
- R10: `claim_dn` and `claim_up` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | A memory transaction address is presented this cycle |
| txn_side | input | 1 | 0 = primary bus, 1 = secondary bus |
| txn_addr | input | ADDR_W | Transaction byte address |
| pf_base | input | ADDR_W-GRAN_W | Prefetchable window base, in 1 MB units |
| pf_limit | input | ADDR_W-GRAN_W | Prefetchable window limit, in 1 MB units, inclusive |
| io_base | input | ADDR_W-GRAN_W | Memory-mapped I/O window base, in 1 MB units |
| io_limit | input | ADDR_W-GRAN_W | Memory-mapped I/O window limit, in 1 MB units, inclusive |
| vga_en | input | 1 | Enables the legacy display range |
| claim_dn | output | 1 | Claim the primary-side transaction and forward it downstream |
| claim_up | output | 1 | Claim the secondary-side transaction and forward it upstream |
| pf_hit | output | 1 | The transaction lies in the prefetchable window |

## Verification
The hardest cases to reach from the ports are those where the windows overlap or touch their boundaries. One is a secondary-side address that misses the prefetchable window but is still blocked by the I/O window or the display range. Another is the last byte of the limit granule. A third is a limit one below the base.

The bench shrinks the address to 24 bits, giving sixteen 1 MB granules. It sweeps every base/limit pair of the prefetchable window, with the I/O window derived from the same loop indices so that it overlaps, abuts, or is disabled. Each granule is probed at its first and last byte, from both sides.

A separate sweep walks the edges of the display range with the enable both on and off. In that sweep the other windows are either disabled or placed over granule 0.

// File: rtl/bridge_window_decode.sv
module bridge_window_decode #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     txn_valid,
  input  logic                     txn_side,
  input  logic [ADDR_W-1:0]        txn_addr,
  input  logic [ADDR_W-GRAN_W-1:0] pf_base,
  input  logic [ADDR_W-GRAN_W-1:0] pf_limit,
  input  logic [ADDR_W-GRAN_W-1:0] io_base,
  input  logic [ADDR_W-GRAN_W-1:0] io_limit,
  input  logic                     vga_en,
  output logic                     claim_dn,
  output logic                     claim_up,
  output logic                     pf_hit
);
  localparam int WIN_W = ADDR_W - GRAN_W;
  localparam logic [ADDR_W-1:0] VGA_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] VGA_HI = ADDR_W'(32'h000B_FFFF);

  logic [WIN_W-1:0] gran;
  logic in_pf, in_io, in_vga, any_win;

  assign gran    = txn_addr[ADDR_W-1:GRAN_W];
  assign in_pf   = (gran >= pf_base) && (gran <= pf_limit);
  assign in_io   = (gran >= io_base) && (gran <= io_limit);
  assign in_vga  = vga_en && (txn_addr >= VGA_LO) && (txn_addr <= VGA_HI);
  assign any_win = in_pf || in_io || in_vga;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_dn <= 1'b0;
      claim_up <= 1'b0;
      pf_hit   <= 1'b0;
    end else begin
      claim_dn <= txn_valid && !txn_side && any_win;
      claim_up <= txn_valid &&  txn_side && !any_win;
      pf_hit   <= txn_valid && in_pf;
    end
  end
endmodule

module bridge_window_decode_chk #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     txn_valid,
  input logic                     txn_side,
  input logic [ADDR_W-1:0]        txn_addr,
  input logic [ADDR_W-GRAN_W-1:0] pf_base,
  input logic [ADDR_W-GRAN_W-1:0] pf_limit,
  input logic [ADDR_W-GRAN_W-1:0] io_base,
  input logic [ADDR_W-GRAN_W-1:0] io_limit,
  input logic                     vga_en,
  input logic                     claim_dn,
  input logic                     claim_up,
  input logic                     pf_hit
);
  p_claims_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_dn && claim_up));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !(claim_dn || claim_up || pf_hit));

  p_dn_from_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_side |=> !claim_dn);

  p_up_from_secondary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_side |=> !claim_up);

  p_pf_primary_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_side ##1 pf_hit |-> claim_dn);

  p_pf_blocks_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_hit |-> !claim_up);

  p_vga_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_side && !vga_en && (pf_limit < pf_base) && (io_limit < io_base)
    |=> !claim_dn);
endmodule

bind bridge_window_decode bridge_window_decode_chk #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_side(txn_side),
  .txn_addr(txn_addr), .pf_base(pf_base), .pf_limit(pf_limit),
  .io_base(io_base), .io_limit(io_limit), .vga_en(vga_en),
  .claim_dn(claim_dn), .claim_up(claim_up), .pf_hit(pf_hit)
);

// File: tb/bridge_window_decode_tb.sv
module bridge_window_decode_tb_top;
  localparam int AW = 24;
  localparam int GW = 20;
  localparam int WW = AW - GW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_valid = 1'b0, txn_side = 1'b0, vga_en = 1'b0;
  logic [AW-1:0] txn_addr = '0;
  logic [WW-1:0] pf_base = '0, pf_limit = '0, io_base = '0, io_limit = '0;
  logic claim_dn, claim_up, pf_hit;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bridge_window_decode #(.ADDR_W(AW), .GRAN_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_side(txn_side),
    .txn_addr(txn_addr), .pf_base(pf_base), .pf_limit(pf_limit),
    .io_base(io_base), .io_limit(io_limit), .vga_en(vga_en),
    .claim_dn(claim_dn), .claim_up(claim_up), .pf_hit(pf_hit));

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h side=%0d got=%0b exp=%0b", req, txn_addr, txn_side, got, exp);
    end
  endtask

  function automatic bit win(input int a, input int b, input int l);
    int lo = b * (1 << GW);
    int hi = l * (1 << GW) + (1 << GW) - 1;
    return (l >= b) && (a >= lo) && (a <= hi);
  endfunction

  task automatic probe(input int a, input bit side, input string tag);
    bit ip, ii, iv, any;
    @(negedge clk);
    txn_valid = 1'b1; txn_side = side; txn_addr = AW'(a);
    ip = win(a, int'(pf_base), int'(pf_limit));
    ii = win(a, int'(io_base), int'(io_limit));
    iv = vga_en && a >= 32'hA0000 && a <= 32'hBFFFF;
    any = ip || ii || iv;
    @(posedge clk); #1;
    check(ip ? {tag, "R2"} : {tag, "R4"}, claim_dn, !side && any);
    check(ip ? {tag, "R3"} : {tag, "R5"}, claim_up, side && !any);
    check({tag, "R6"}, pf_hit, ip);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset dn", claim_dn, 1'b0);
    check("R1 reset up", claim_up, 1'b0);
    check("R1 reset hit", pf_hit, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", claim_dn | claim_up | pf_hit, 1'b0);

    // R7: every base/limit pair, first and last byte of every granule
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < 16; l++) begin
        @(negedge clk);
        pf_base = WW'(b); pf_limit = WW'(l);
        io_base = WW'((b + 7) & 15); io_limit = WW'((l + 3) & 15);
        vga_en = b[0];
        for (int g = 0; g < 16; g++) begin
          for (int s = 0; s < 2; s++) begin
            probe(g << GW, s[0], "R7 lo ");
            probe((g << GW) + 32'hFFFFF, s[0], "R7 hi ");
          end
        end
      end
    end

    // R8: display range edges with the enable on and off
    for (int cfg = 0; cfg < 4; cfg++) begin
      @(negedge clk);
      vga_en = cfg[0];
      pf_base = 4'd1; pf_limit = 4'd0;
      if (cfg[1]) begin io_base = 4'd0; io_limit = 4'd0; end
      else begin io_base = 4'd2; io_limit = 4'd1; end
      for (int s = 0; s < 2; s++) begin
        probe(32'h9FFFF, s[0], "R8 ");
        probe(32'hA0000, s[0], "R8 ");
        probe(32'hB1234, s[0], "R8 ");
        probe(32'hBFFFF, s[0], "R8 ");
        probe(32'hC0000, s[0], "R8 ");
      end
    end

    // R9: invalid cycle inside every window yields nothing
    @(negedge clk);
    pf_base = 4'd0; pf_limit = 4'd15; io_base = 4'd0; io_limit = 4'd15; vga_en = 1'b1;
    txn_valid = 1'b0; txn_side = 1'b0; txn_addr = 24'h0A_0000;
    @(posedge clk); #1;
    check("R9 idle dn", claim_dn, 1'b0);
    check("R9 idle hit", pf_hit, 1'b0);
    @(negedge clk); txn_side = 1'b1; pf_base = 4'd1; pf_limit = 4'd0;
    io_base = 4'd1; io_limit = 4'd0; vga_en = 1'b0;
    @(posedge clk); #1;
    check("R9 idle up", claim_up, 1'b0);
    check("R10 exclusive", claim_dn & claim_up, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); n_chk++; n_bad++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule